// File: doc/BRIEF.md
# Memory bit-error-rate self-test engine

This engine measures how many stored bits a memory region loses at one operating point. It drives a simple synchronous memory master port. In each iteration it fills a configured address range, one word per cycle in ascending order, with a pseudo-random word stream. It then reads the range back, rebuilds the same stream from the same seed, and adds up the number of bits that differ.

The engine repeats this for a programmed number of iterations. Each iteration starts from a fresh seed that is derived from the previous one, so no location receives the same pattern twice. Two wide counters, one for flipped bits and one for bits observed, stay in flip-flops outside the memory under test. Their ratio gives the error rate. The counters can be read on the output ports at any time. They stay frozen once the run finishes.

Top module: `bert_engine`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o` and `mem_req_o` are low and both counters read zero.
- R2: A `start_i` pulse is accepted only in a cycle where `busy_o` is low. Acceptance captures range, count and seed. Further `start_i` pulses and changes on the configuration ports during a run have no effect on the run's accesses, data or counts.
- R3: The write phase writes addresses `addr_lo_i` up to `addr_hi_i` in ascending order, one per cycle. The first word is the iteration seed, and each following word is D(previous), where D(x) = (x << 1) ^ (x[31] ? 32'h0040_0007 : 0). No address outside the range is written.
- R4: The read phase starts in the cycle after the last write. It reads the same addresses in the same order, one per cycle, and takes the read data one cycle after each read request.
- R5: For each word read, the error counter adds popcount(read data XOR regenerated word) and the bits-seen counter adds 32. Both counters are 64-bit and saturating, and both clear when a start is accepted.
- R6: The first iteration uses `seed_i`, with a zero seed replaced by 32'h0000_0001. Iteration k+1 uses S(seed of k), where S(x) = (x << 1) ^ (x[31] ? 32'h04C1_1DB7 : 0).
- R7: The run performs `iter_count_i` iterations, and a count of zero runs one iteration.
- R8: For a range of N words and I iterations, `busy_o` stays high for exactly I*(2N+1) cycles. `done_o` rises as `busy_o` falls and holds until the next accepted start. The two are never high together.
- R9: `mem_req_o` is high only while busy, and `mem_we_o` is high only together with `mem_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| addr_lo_i | input | AW | First address of the range |
| addr_hi_i | input | AW | Last address of the range |
| iter_count_i | input | IW | Number of iterations (0 means 1) |
| seed_i | input | 32 | Seed of the first iteration |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable (low means read) |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run finished |
| err_count_o | output | CW | Flipped bits counted |
| bits_seen_o | output | CW | Bits compared |

## Verification
The assertions check the port rules on every cycle. They cover quiet memory outside a run, write enable only within a request and ascending addresses inside a phase. They also cover a monotone error count, a bits-seen count that moves only by 0 or 32, exclusive busy and done, and a done flag that holds.

Only the bench's scenarios can show the rest. That covers the exact error totals against stuck bits, and the word stream and seed chain, which are visible in the memory left behind. It also covers the zero-seed and zero-count substitutions, the exact run length and the immunity to configuration changes during a run.

// File: rtl/bert_pkg.sv
package bert_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] DATA_POLY = 32'h0040_0007;
  localparam logic [WORD_W-1:0] SEED_POLY = 32'h04C1_1DB7;
  localparam logic [WORD_W-1:0] SEED_SUBST = 32'h0000_0001;

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_READ, ST_NEXT} bert_state_e;

  // Galois left shift; a nonzero state never maps to zero since poly[0] is set.
  function automatic logic [WORD_W-1:0] lfsr_next(input logic [WORD_W-1:0] s,
                                                  input logic [WORD_W-1:0] poly);
    return {s[WORD_W-2:0], 1'b0} ^ (s[WORD_W-1] ? poly : '0);
  endfunction
endpackage

// File: rtl/bert_gen.sv
module bert_gen
  import bert_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] seed_i,
  input  logic              step_i,
  input  logic              replay_i,
  input  logic              reseed_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] iter_seed_q, iter_seed_d, word_q, word_d, seed_fix, seed_adv;
  logic              seed_en, word_en;

  always_comb begin
    seed_fix = (seed_i == '0) ? SEED_SUBST : seed_i;
    seed_adv = lfsr_next(iter_seed_q, SEED_POLY);
    seed_en  = load_i | reseed_i;
    word_en  = load_i | reseed_i | replay_i | step_i;
    iter_seed_d = load_i ? seed_fix : seed_adv;
    if (load_i)        word_d = seed_fix;
    else if (reseed_i) word_d = seed_adv;
    else if (replay_i) word_d = iter_seed_q;
    else               word_d = lfsr_next(word_q, DATA_POLY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iter_seed_q <= '0;
      word_q      <= '0;
    end else begin
      if (seed_en) iter_seed_q <= iter_seed_d;
      if (word_en) word_q      <= word_d;
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/bert_ctrl.sv
module bert_ctrl
  import bert_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_lo_i,
  input  logic [AW-1:0] addr_hi_i,
  input  logic [IW-1:0] iter_count_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          load_o,
  output logic          step_o,
  output logic          replay_o,
  output logic          reseed_o,
  output logic          cmp_o,
  output logic          busy_o,
  output logic          done_o
);
  bert_state_e   state_q, state_d;
  logic [AW-1:0] addr_q, addr_d, lo_q, hi_q;
  logic [IW-1:0] left_q, left_d;
  logic          done_q, done_d, accept, last, more, addr_en, left_en;

  always_comb begin
    accept   = start_i && (state_q == ST_IDLE);
    last     = (addr_q == hi_q);
    more     = (left_q > IW'(1));
    state_d  = state_q;
    addr_d   = last ? lo_q : addr_q + AW'(1);
    left_d   = left_q - IW'(1);
    done_d   = done_q;
    addr_en  = 1'b0;
    left_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_WRITE;
        addr_d  = addr_lo_i;
        left_d  = (iter_count_i == '0) ? IW'(1) : iter_count_i;
        addr_en = 1'b1;
        left_en = 1'b1;
        done_d  = 1'b0;
      end
      ST_WRITE: begin
        addr_en = 1'b1;
        if (last) state_d = ST_READ;
      end
      ST_READ: begin
        addr_en = 1'b1;
        if (last) state_d = ST_NEXT;
      end
      ST_NEXT: begin
        if (more) begin
          state_d = ST_WRITE;
          left_en = 1'b1;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (addr_en) addr_q <= addr_d;
      if (left_en) left_q <= left_d;
      if (accept) begin
        lo_q <= addr_lo_i;
        hi_q <= addr_hi_i;
      end
    end
  end

  assign mem_req_o  = (state_q == ST_WRITE) || (state_q == ST_READ);
  assign mem_we_o   = (state_q == ST_WRITE);
  assign mem_addr_o = addr_q;
  assign load_o     = accept;
  assign step_o     = ((state_q == ST_WRITE) && !last) || (state_q == ST_READ);
  assign replay_o   = (state_q == ST_WRITE) && last;
  assign reseed_o   = (state_q == ST_NEXT) && more;
  assign cmp_o      = (state_q == ST_READ);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/bert_accum.sv
module bert_accum
  import bert_pkg::*;
#(
  parameter int CW = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              cmp_i,
  input  logic [WORD_W-1:0] exp_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [CW-1:0]     err_o,
  output logic [CW-1:0]     bits_o
);
  localparam int FW = $clog2(WORD_W + 1);
  localparam logic [CW:0] BITS_INC = (CW+1)'(WORD_W);

  logic              vld_q;
  logic [WORD_W-1:0] exp_q;
  logic [CW-1:0]     err_q, err_d, bits_q, bits_d;
  logic [FW-1:0]     flips;
  logic [CW:0]       err_sum, bits_sum;
  logic              cnt_en;

  always_comb begin
    flips    = FW'($countones(rdata_i ^ exp_q));
    err_sum  = {1'b0, err_q} + {{(CW+1-FW){1'b0}}, flips};
    bits_sum = {1'b0, bits_q} + BITS_INC;
    cnt_en   = clear_i | vld_q;
    if (clear_i) begin
      err_d  = '0;
      bits_d = '0;
    end else begin
      err_d  = err_sum[CW]  ? '1 : err_sum[CW-1:0];
      bits_d = bits_sum[CW] ? '1 : bits_sum[CW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      exp_q  <= '0;
      err_q  <= '0;
      bits_q <= '0;
    end else begin
      vld_q <= cmp_i;
      if (cmp_i) exp_q <= exp_i;
      if (cnt_en) begin
        err_q  <= err_d;
        bits_q <= bits_d;
      end
    end
  end

  assign err_o  = err_q;
  assign bits_o = bits_q;
endmodule

// File: rtl/bert_engine.sv
module bert_engine
  import bert_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 16,
  parameter int CW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_lo_i,
  input  logic [AW-1:0] addr_hi_i,
  input  logic [IW-1:0] iter_count_i,
  input  logic [31:0]   seed_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] err_count_o,
  output logic [CW-1:0] bits_seen_o
);
  logic              load, step, replay, reseed, cmp;
  logic [WORD_W-1:0] word;

  bert_ctrl #(.AW(AW), .IW(IW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .addr_lo_i, .addr_hi_i, .iter_count_i,
    .mem_req_o, .mem_we_o, .mem_addr_o,
    .load_o(load), .step_o(step), .replay_o(replay), .reseed_o(reseed),
    .cmp_o(cmp), .busy_o, .done_o
  );

  bert_gen u_gen (
    .clk_i, .rst_ni, .load_i(load), .seed_i, .step_i(step),
    .replay_i(replay), .reseed_i(reseed), .word_o(word)
  );

  bert_accum #(.CW(CW)) u_accum (
    .clk_i, .rst_ni, .clear_i(load), .cmp_i(cmp), .exp_i(word),
    .rdata_i(mem_rdata_i), .err_o(err_count_o), .bits_o(bits_seen_o)
  );

  assign mem_wdata_o = word;
endmodule

// File: rtl/bert_engine_chk.sv
module bert_engine_chk #(
  parameter int AW = 8,
  parameter int CW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] err_count_o,
  input logic [CW-1:0] bits_seen_o
);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  p_we_in_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);
  p_busy_done_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);
  p_start_taken_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o && !done_o);
  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && $past(mem_req_o) && (mem_we_o == $past(mem_we_o))
    |-> mem_addr_o == $past(mem_addr_o) + AW'(1));
  p_err_grows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) && busy_o |-> err_count_o >= $past(err_count_o));
  p_bits_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) && busy_o |-> (bits_seen_o == $past(bits_seen_o)) ||
                                (bits_seen_o == $past(bits_seen_o) + CW'(32)));
  p_err_le_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_count_o <= bits_seen_o);
endmodule

bind bert_engine bert_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mem_req_o(mem_req_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .busy_o(busy_o),
  .done_o(done_o), .err_count_o(err_count_o), .bits_seen_o(bits_seen_o)
);

// File: tb/bert_engine_tb.sv
module bert_engine_tb;
  localparam int AW = 8;
  localparam int IW = 16;
  localparam int CW = 64;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] addr_lo_i, addr_hi_i;
  logic [IW-1:0] iter_count_i;
  logic [31:0]   seed_i;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_wdata_o, mem_rdata_i;
  logic          busy_o, done_o;
  logic [CW-1:0] err_count_o, bits_seen_o;

  int n_chk = 0;
  int n_bad = 0;
  int wd = 0;

  logic [31:0] mem [DEPTH];
  logic [31:0] stk_msk [DEPTH];
  logic [31:0] stk_val [DEPTH];

  always #4 clk = ~clk;

  bert_engine #(.AW(AW), .IW(IW), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .addr_lo_i, .addr_hi_i,
    .iter_count_i, .seed_i, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .busy_o, .done_o, .err_count_o, .bits_seen_o
  );

  // Memory under test: stuck bits show up on read only.
  always @(posedge clk) begin
    if (mem_req_o && mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    if (mem_req_o && !mem_we_o)
      mem_rdata_i <= (mem[mem_addr_o] & ~stk_msk[mem_addr_o]) |
                     (stk_val[mem_addr_o] & stk_msk[mem_addr_o]);
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_bad++;
      $display("FAIL R8 watchdog expired: actual %0d cycles, expected < 150000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] d_next(input logic [31:0] x);
    return (x << 1) ^ (x[31] ? 32'h0040_0007 : 32'h0);
  endfunction
  function automatic logic [31:0] s_next(input logic [31:0] x);
    return (x << 1) ^ (x[31] ? 32'h04C1_1DB7 : 32'h0);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic prep_mem();
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 32'hDEAD_0000 | 32'(i);
      stk_msk[i] = '0;
      stk_val[i] = '0;
    end
  endtask

  // Launch one run and check every result at the ports and in the memory.
  task automatic run_case(input string name, input int lo, input int hi,
                          input int cnt, input logic [31:0] seed, input bit disturb);
    int n, it, cyc, bad_in, bad_out;
    logic [31:0] s, w, rd;
    logic [63:0] exp_err;
    n  = hi - lo + 1;
    it = (cnt == 0) ? 1 : cnt;
    s  = (seed == 0) ? 32'h1 : seed;
    exp_err = 0;
    for (int k = 0; k < it; k++) begin
      w = s;
      for (int j = 0; j < n; j++) begin
        rd = (w & ~stk_msk[lo+j]) | (stk_val[lo+j] & stk_msk[lo+j]);
        exp_err += 64'($countones(rd ^ w));
        w = d_next(w);
      end
      if (k < it - 1) s = s_next(s);
    end
    @(negedge clk);
    addr_lo_i = AW'(lo); addr_hi_i = AW'(hi);
    iter_count_i = IW'(cnt); seed_i = seed; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({name, " R8 done clears on start"}, 64'(done_o), 64'd0);
    check({name, " R5 counters clear on start"}, err_count_o | bits_seen_o, 64'd0);
    cyc = 0;
    while (busy_o && cyc < 20000) begin
      cyc++;
      if (disturb && cyc == 3) begin
        seed_i = ~seed_i; addr_lo_i = '0; addr_hi_i = '1;
        iter_count_i = 9; start_i = 1'b1;
      end
      if (disturb && cyc == 4) start_i = 1'b0;
      @(negedge clk);
    end
    check({name, " R8 busy length (R4 read follows write)"}, 64'(cyc), 64'(it * (2*n + 1)));
    check({name, " R8 done after run"}, 64'(done_o), 64'd1);
    check({name, " R5 error bits"}, err_count_o, exp_err);
    check({name, " R5 R7 bits seen"}, bits_seen_o, 64'(it) * 64'(n) * 64'd32);
    bad_in = 0; bad_out = 0; w = s;
    for (int a = 0; a < DEPTH; a++) begin
      if (a >= lo && a <= hi) begin
        if (mem[a] !== w) bad_in++;
        w = d_next(w);
      end else if (mem[a] !== (32'hDEAD_0000 | 32'(a))) bad_out++;
    end
    check({name, " R3 R6 last pattern words wrong"}, 64'(bad_in), 64'd0);
    check({name, " R3 outside range touched"}, 64'(bad_out), 64'd0);
  endtask

  task automatic t_reset();
    check("R1 busy in reset", 64'(busy_o), 64'd0);
    check("R1 req in reset", 64'(mem_req_o), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 busy after reset", 64'(busy_o), 64'd0);
    check("R1 done after reset", 64'(done_o), 64'd0);
    check("R1 counters after reset", err_count_o | bits_seen_o, 64'd0);
  endtask

  task automatic t_clean();
    prep_mem();
    run_case("clean R3", 10, 25, 3, 32'h1234_5678, 1'b0);
  endtask

  task automatic t_stuck();
    prep_mem();
    stk_msk[42] = 32'h0000_00F0; stk_val[42] = 32'h0;
    stk_msk[45] = 32'h8000_0001; stk_val[45] = 32'hFFFF_FFFF;
    stk_msk[47] = 32'hFFFF_FFFF; stk_val[47] = 32'h5A5A_A5A5;
    run_case("stuck R5", 40, 47, 4, 32'hCAFE_F00D, 1'b0);
  endtask

  task automatic t_zero_seed();
    prep_mem();
    run_case("zero seed R6", 0, 3, 2, 32'h0, 1'b0);
  endtask

  task automatic t_zero_count();
    prep_mem();
    run_case("zero count single word R7", 200, 200, 0, 32'h8000_0000, 1'b0);
  endtask

  task automatic t_disturb();
    prep_mem();
    stk_msk[65] = 32'h00FF_0000; stk_val[65] = 32'h0012_0000;
    run_case("config change ignored R2", 60, 71, 2, 32'h0F0F_1234, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; addr_lo_i = '0; addr_hi_i = '0;
    iter_count_i = '0; seed_i = '0;
    prep_mem();
    repeat (3) @(negedge clk);
    t_reset();
    t_clean();
    t_stuck();
    t_zero_seed();
    t_zero_count();
    t_disturb();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule